// File: doc/BRIEF.md
# Receive-Clock Delay-Line Phase Switch Sequencer

This block moves the receive-clock delay line of a card interface to a new sampling phase without glitching the sampled clock. A one-cycle start pulse carries a 4-bit phase number (0 to 15). The block runs a fixed handshake on the delay line's clock-output-enable status. It first gates the output clock off and waits until the delay line confirms that the clock is off. Only then does it write the phase, Gray-coded, into the phase-select field. It then re-enables the output clock, waits for confirmation that the clock is back on, and returns sampling to the internal clock-data recovery loop.

The block drives a 32-bit configuration word whose fields a neighbouring delay-line macro decodes. Every wait is bounded. The poll interval is a prescaled count of core clocks, and a wait gives up after a parameterised number of intervals. When a wait gives up, the block stops at once, leaves the word as it stands, and reports done together with an error. A successful sequence reports done alone.

Top module: `dll_phase_seq`

## Requirements
- R1: After reset the configuration word is all zeros, and busy, done and err are 0.
- R2: A start accepted while idle takes effect at the next clock edge. In that cycle busy is 1, the word has the DLL enable (bit 16) set, the external recovery select (bit 19) set, and both the recovery enable (bit 17) and the clock-output enable (bit 18) cleared.
- R3: Each status wait gives up after MAX_POLLS intervals of TICK_CYCLES clocks. On giving up, done and err pulse together and every field of the word keeps the value it had during the wait.
- R4: The phase number p is written to bits 23:20 as p XOR (p >> 1). In order from phase 0 to phase 15 the codes are 0,1,3,2,6,7,5,4,C,D,F,E,A,B,9,8.
- R5: The phase field changes only while the clock-output enable (bit 18) is 0, and only after the status input has read 0 in the current sequence.
- R6: After the phase is written, bit 18 is set, and the block waits for the status input to read 1.
- R7: On success the final word has bits 16, 17 and 18 set, bit 19 cleared and the new code in bits 23:20. done pulses with err low.
- R8: A start pulse while busy is ignored. The phase number is captured when start is accepted, and later changes to the phase input have no effect.
- R9: done and err are each high for exactly one cycle per sequence, and err is never high without done.
- R10: The recovery enable and the external recovery select are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to switch phase |
| phase_in | input | 4 | Requested phase number, 0 to 15 |
| ck_status | input | 1 | Clock-output-enable status from the delay line |
| cfg_word | output | 32 | Delay-line configuration word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | One-cycle timeout pulse, coincident with done |

## Verification
The bench drives a delay-line model whose status follows the clock-output enable after a random latency. It also makes the status stick high, which stalls the first wait, and stick low, which stalls the second. A design that did not bound its waits would hang. A design that reset the fields on a timeout would show a cleared or stale word at the error pulse. All sixteen phases are run and checked against the code table, so a plain binary write or a reversed Gray code shows up in bits 23:20. A second start with a different phase during a run checks that the captured phase is used and that no extra done appears. A monitor flags any phase-field change while bit 18 is set.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int DLL_EN_BIT  = 16;
  localparam int CDR_EN_BIT  = 17;
  localparam int CK_EN_BIT   = 18;
  localparam int EXT_SEL_BIT = 19;
  localparam int PH_LSB      = 20;
  localparam int PH_W        = 4;
  localparam int WORD_W      = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_OFF,
    ST_WR_PHASE,
    ST_CK_ON,
    ST_WAIT_ON
  } seq_state_t;

  function automatic logic [PH_W-1:0] to_gray(input logic [PH_W-1:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/dps_poll_timer.sv
module dps_poll_timer #(
  parameter int TICK_CYCLES = 50,
  parameter int MAX_POLLS   = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic expired
);
  localparam int PRE_W  = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int POLL_W = $clog2(MAX_POLLS + 1);
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(TICK_CYCLES - 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(MAX_POLLS);

  logic [PRE_W-1:0]  pre_q;
  logic [POLL_W-1:0] polls_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_q   <= '0;
      polls_q <= '0;
    end else if (pre_q == PRE_LAST) begin
      pre_q <= '0;
      if (polls_q != POLL_LAST) polls_q <= polls_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign expired = (polls_q == POLL_LAST);

  p_polls_bounded_r3: assert property (@(posedge clk) disable iff (rst)
    polls_q <= POLL_LAST);
  p_clear_restarts_r3: assert property (@(posedge clk) disable iff (rst)
    clear |=> polls_q == '0);
endmodule

// File: rtl/dps_ctrl.sv
module dps_ctrl
  import dps_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [PH_W-1:0] phase_in,
  input  logic            ck_status,
  input  logic            expired,
  output logic            tmr_clr,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic            cdr_en,
  output logic            ext_sel,
  output logic            dll_en,
  output logic            ck_en,
  output logic [PH_W-1:0] phase_sel
);
  seq_state_t      state_q;
  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      phase_q   <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      cdr_en    <= 1'b0;
      ext_sel   <= 1'b0;
      dll_en    <= 1'b0;
      ck_en     <= 1'b0;
      phase_sel <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          phase_q <= phase_in;
          cdr_en  <= 1'b0;
          ck_en   <= 1'b0;
          ext_sel <= 1'b1;
          dll_en  <= 1'b1;
          state_q <= ST_WAIT_OFF;
        end
        ST_WAIT_OFF: begin
          if (!ck_status) begin
            state_q <= ST_WR_PHASE;
          end else if (expired) begin
            done    <= 1'b1;
            err     <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_WR_PHASE: begin
          phase_sel <= to_gray(phase_q);
          state_q   <= ST_CK_ON;
        end
        ST_CK_ON: begin
          ck_en   <= 1'b1;
          state_q <= ST_WAIT_ON;
        end
        ST_WAIT_ON: begin
          if (ck_status) begin
            cdr_en  <= 1'b1;
            ext_sel <= 1'b0;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else if (expired) begin
            done    <= 1'b1;
            err     <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign tmr_clr = (state_q != ST_WAIT_OFF) && (state_q != ST_WAIT_ON);

  p_phase_gated_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase_sel) |-> !ck_en && !$past(ck_en));
  p_ck_on_after_phase_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ck_en) |-> $past(state_q) == ST_CK_ON);
endmodule

// File: rtl/dll_phase_seq.sv
module dll_phase_seq #(
  parameter int TICK_CYCLES = 50,
  parameter int MAX_POLLS   = 50
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [3:0]  phase_in,
  input  logic        ck_status,
  output logic [31:0] cfg_word,
  output logic        busy,
  output logic        done,
  output logic        err
);
  import dps_pkg::*;

  logic            tmr_clr, expired;
  logic            cdr_en, ext_sel, dll_en, ck_en;
  logic [PH_W-1:0] phase_sel;

  dps_poll_timer #(
    .TICK_CYCLES(TICK_CYCLES),
    .MAX_POLLS  (MAX_POLLS)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (tmr_clr),
    .expired(expired)
  );

  dps_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .phase_in (phase_in),
    .ck_status(ck_status),
    .expired  (expired),
    .tmr_clr  (tmr_clr),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .cdr_en   (cdr_en),
    .ext_sel  (ext_sel),
    .dll_en   (dll_en),
    .ck_en    (ck_en),
    .phase_sel(phase_sel)
  );

  always_comb begin
    cfg_word                           = '0;
    cfg_word[DLL_EN_BIT]               = dll_en;
    cfg_word[CDR_EN_BIT]               = cdr_en;
    cfg_word[CK_EN_BIT]                = ck_en;
    cfg_word[EXT_SEL_BIT]              = ext_sel;
    cfg_word[PH_LSB +: PH_W]           = phase_sel;
  end

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_cdr_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(cfg_word[CDR_EN_BIT] && cfg_word[EXT_SEL_BIT]));
  p_ignore_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !done) |=> busy || done);
  p_timeout_holds_r3: assert property (@(posedge clk) disable iff (rst)
    err |-> $stable(cfg_word));
endmodule

// File: tb/tb_dll_phase_seq.sv
module tb_dll_phase_seq;
  localparam int TICK = 4;
  localparam int POLLS = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  phase_in = '0;
  logic        ck_status = 1'b0;
  logic [31:0] cfg_word;
  logic        busy, done, err;

  int checks = 0;
  int fails = 0;
  int done_seen = 0;
  int stat_mode = 0;   // 0 follow, 1 hold, 2 stuck low
  int lat = 0;
  logic [31:0] prev_word = '0;

  typedef struct packed { logic [31:0] word; logic e; } exp_t;
  exp_t exp_q[$];

  logic [3:0] gray_tbl [16] = '{4'h0,4'h1,4'h3,4'h2,4'h6,4'h7,4'h5,4'h4,
                                4'hC,4'hD,4'hF,4'hE,4'hA,4'hB,4'h9,4'h8};

  dll_phase_seq #(.TICK_CYCLES(TICK), .MAX_POLLS(POLLS)) dut (
    .clk(clk), .rst(rst), .start(start), .phase_in(phase_in),
    .ck_status(ck_status), .cfg_word(cfg_word), .busy(busy),
    .done(done), .err(err));

  always #10 clk = ~clk;

  // delay-line status model
  always @(posedge clk) begin
    if (rst) begin
      ck_status <= 1'b0;
      lat <= 0;
    end else if (stat_mode == 2) begin
      ck_status <= 1'b0;
    end else if (stat_mode == 0 && ck_status != cfg_word[18]) begin
      if (lat == 0) begin
        ck_status <= cfg_word[18];
        lat <= int'($urandom_range(5, 0));
      end else lat <= lat - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor: scoreboard pop and phase-gating watch
  always @(negedge clk) begin
    if (!rst) begin
      if (cfg_word[23:20] != prev_word[23:20])
        chk(!cfg_word[18] && !prev_word[18], "R5", cfg_word, prev_word);
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected done", cfg_word, 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(cfg_word == e.word, e.e ? "R3 word" : "R7 word", cfg_word, e.word);
          chk(err == e.e, "R9 err", {31'b0, err}, {31'b0, e.e});
        end
        done_seen++;
      end
      prev_word = cfg_word;
    end
  end

  function automatic logic [31:0] mk(input bit dll, cdr, ck, ext, input logic [3:0] ph);
    logic [31:0] w;
    w = '0; w[16] = dll; w[17] = cdr; w[18] = ck; w[19] = ext; w[23:20] = ph;
    return w;
  endfunction

  logic [3:0] cur_code = '0;

  // outcome: 0 success, 1 timeout first wait, 2 timeout second wait
  task automatic run_seq(input logic [3:0] ph, input int outcome, input bit poke);
    int n;
    exp_t e;
    n = done_seen;
    if (outcome == 0) begin
      e.word = mk(1, 1, 1, 0, gray_tbl[ph]); e.e = 0; cur_code = gray_tbl[ph];
    end else if (outcome == 1) begin
      e.word = mk(1, 0, 0, 1, cur_code); e.e = 1;
    end else begin
      e.word = mk(1, 0, 1, 1, gray_tbl[ph]); e.e = 1; cur_code = gray_tbl[ph];
    end
    exp_q.push_back(e);
    @(negedge clk);
    phase_in = ph; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2 first-step check
    chk(busy && cfg_word[16] && cfg_word[19] && !cfg_word[17] && !cfg_word[18],
        "R2", cfg_word, mk(1, 0, 0, 1, cfg_word[23:20]));
    if (poke) begin
      phase_in = ph ^ 4'h5;   // R8: later input change and a start while busy
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_seen == n) @(negedge clk);
    chk(!done && !err, "R9 pulse width", {30'b0, done, err}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cfg_word == 0 && !busy && !done && !err, "R1",
        {cfg_word[31:3], busy, done, err}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_word == 0 && !busy, "R1 after release", cfg_word, 32'h0);
    // R4/R7: every phase in turn
    for (int p = 0; p < 16; p++) run_seq(4'(p), 0, 1'b0);
    // R8: start while busy with changed phase
    run_seq(4'd6, 0, 1'b1);
    repeat (30) @(negedge clk);
    chk(!busy && exp_q.size() == 0, "R8 no extra run", {31'b0, busy}, 32'h0);
    // R3: status stuck high during first wait
    stat_mode = 1;
    run_seq(4'd11, 1, 1'b0);
    stat_mode = 0;
    repeat (20) @(negedge clk);
    // R3/R6: status stuck low during second wait
    stat_mode = 2;
    run_seq(4'd3, 2, 1'b0);
    stat_mode = 0;
    repeat (20) @(negedge clk);
    // recovery after timeout
    run_seq(4'd9, 0, 1'b0);
    run_seq(4'd0, 0, 1'b0);
    chk(exp_q.size() == 0, "R9 all results seen", 32'(exp_q.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule